// File: doc/BRIEF.md
# Memory Module Presence-Detect Target

This block is the two-wire serial target that sits on a memory module. It answers a host over a shared clock line and a bidirectional data line, and it gives read and write access to a 256-byte configuration store. Up to eight modules can share one bus. Three strap inputs tie each module to one slot, and the low three bits of the bus address come from those straps. The data line is open-drain. The block never drives it high: it pulls the line low by asserting an output enable.

The host's first byte after a start condition is a 7-bit address plus a direction bit. In a write, the first data byte loads the internal byte pointer, and each later data byte is stored at the pointer, which then moves on. A read, either straight after the address or after a repeated start, returns bytes from the pointer and steps it forward. The pointer wraps at the top of the store. A protect input blocks changes to the store. The same input also hides a second address window that is reserved for unprotected modules. After reset the store holds a parameter image.

Top module: `pd_target`

## Requirements
- R1: An address byte whose upper four address bits are 1010 (addresses 0x50..0x57) and whose low three bits equal `strap_i` is acknowledged: SDA is held low during the ninth clock.
- R2: Addresses 0x30..0x37 (upper bits 0110, low bits equal to `strap_i`) are acknowledged only while `wp_i` is 0. While `wp_i` is 1 they are not acknowledged.
- R3: An address that does not match is not acknowledged, and SDA stays released for every later clock until the next start condition.
- R4: In a write transfer, the first data byte sets the byte pointer. Each later data byte is stored at the pointer and the pointer then steps by one. Every data byte is acknowledged.
- R5: While `wp_i` is 1, write data bytes are still acknowledged, but the store contents do not change.
- R6: A pointer write followed by a repeated start and a read address returns the byte at that pointer, then the bytes that follow it.
- R7: Sequential reads step the pointer by one per byte sent, wrapping from 255 to 0.
- R8: When the host answers a read byte with NACK (SDA high on the ninth clock), the target releases SDA and sends nothing more in that transfer.
- R9: The output enable changes only while SCL is low, and a stop condition leaves SDA released.
- R10: During and after reset SDA is released, the pointer is 0, and the store byte at index i holds ((i*37) mod 256) XOR 0x5C.
- R11: A read issued straight after the address byte, with no pointer write, continues from the pointer that the previous transfer left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Data value driven when enabled, always 0 (open-drain) |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| strap_i | input | 3 | Slot-select straps, low three address bits |
| wp_i | input | 1 | Write protect: blocks store updates and the alias window |

## Verification
The assertions assume a legal bus. SCL must stay at each level for well over three clock cycles, SDA may change only while SCL is low except at start and stop conditions, and no start or stop may occur while the target is pulling SDA low. The host model in the bench holds every SCL phase for ten cycles, changes SDA only in the low phase or inside its start and stop sequences, and issues stops only after a released acknowledge or a host NACK. Under these limits, the rule that the enable changes only while SCL is low can be checked against the raw pad clock.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int STORE_DEPTH = 256;
  localparam int STORE_AW    = $clog2(STORE_DEPTH);
  localparam int STORE_BITS  = STORE_DEPTH * 8;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RX   = 3'd1,
    PH_ACK  = 3'd2,
    PH_TX   = 3'd3,
    PH_HACK = 3'd4
  } phase_t;

  // default store content for byte i
  function automatic logic [7:0] image_byte(input int unsigned i);
    logic [31:0] t;
    t = (i * 32'd37) ^ 32'h0000_005C;
    return t[7:0];
  endfunction

  function automatic logic [STORE_BITS-1:0] build_image();
    logic [STORE_BITS-1:0] img;
    img = '0;
    for (int i = 0; i < STORE_DEPTH; i++) img[i*8 +: 8] = image_byte(i);
    return img;
  endfunction

  // 7-bit address decode: slot bits plus primary or (unprotected) alias window
  function automatic logic addr_hit(input logic [6:0] a, input logic [2:0] slot,
                                    input logic prot, input logic [3:0] base_hi,
                                    input logic [3:0] alias_hi);
    return (a[2:0] == slot) &&
           ((a[6:3] == base_hi) || (!prot && (a[6:3] == alias_hi)));
  endfunction

  function automatic logic [STORE_AW-1:0] step_ptr(input logic [STORE_AW-1:0] p);
    return p + STORE_AW'(1);
  endfunction
endpackage

// File: rtl/pd_linesync.sv
module pd_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_vec;
  logic [NLINES-1:0] lvl_vec;
  logic [NLINES-1:0] prev_vec;

  assign raw_vec = {sda_raw, scl_raw};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain       <= '1;
        prev_vec[g] <= 1'b1;
      end else begin
        chain       <= {chain[STAGES-2:0], raw_vec[g]};
        prev_vec[g] <= chain[STAGES-1];
      end
    end
    assign lvl_vec[g] = chain[STAGES-1];
  end

  assign scl_lvl  = lvl_vec[0];
  assign sda_lvl  = lvl_vec[1];
  assign scl_rise = lvl_vec[0] & ~prev_vec[0];
  assign scl_fall = ~lvl_vec[0] & prev_vec[0];
  assign start_ev = lvl_vec[0] & prev_vec[0] & prev_vec[1] & ~lvl_vec[1];
  assign stop_ev  = lvl_vec[0] & prev_vec[0] & ~prev_vec[1] & lvl_vec[1];
endmodule

// File: rtl/pd_store.sv
module pd_store #(
  parameter int DEPTH = pd_pkg::STORE_DEPTH,
  parameter int AW    = pd_pkg::STORE_AW,
  parameter logic [DEPTH*8-1:0] IMAGE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= IMAGE[i*8 +: 8];
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/pd_engine.sv
module pd_engine #(
  parameter int         AW       = pd_pkg::STORE_AW,
  parameter logic [3:0] BASE_HI  = 4'hA,
  parameter logic [3:0] ALIAS_HI = 4'h6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [2:0]    slot,
  input  logic          prot,
  input  logic [7:0]    rdata,
  output logic          pull_low,
  output logic          st_we,
  output logic [AW-1:0] ptr,
  output logic [7:0]    wdata,
  output logic          ev_addr_ack,
  output logic          ev_addr_nack,
  output logic [6:0]    ev_addr,
  output logic          ev_load
);
  import pd_pkg::*;

  phase_t     ph;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [7:0] tx;
  logic       got;
  logic       is_addr;
  logic       rd;
  logic       first;
  logic       more;
  logic       hit;
  logic       byte_in;

  assign hit          = addr_hit(sh[7:1], slot, prot, BASE_HI, ALIAS_HI);
  assign byte_in      = (ph == PH_RX) && scl_fall && got;
  assign ev_addr      = sh[7:1];
  assign ev_addr_ack  = byte_in && is_addr && hit;
  assign ev_addr_nack = byte_in && is_addr && !hit;
  assign st_we        = byte_in && !is_addr && !first && !prot;
  assign wdata        = sh;
  assign ev_load      = scl_fall && (((ph == PH_ACK) && rd) || ((ph == PH_HACK) && more));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      got      <= 1'b0;
      is_addr  <= 1'b0;
      rd       <= 1'b0;
      first    <= 1'b0;
      more     <= 1'b0;
      ptr      <= '0;
      pull_low <= 1'b0;
    end else if (start_ev) begin
      ph       <= PH_RX;
      is_addr  <= 1'b1;
      cnt      <= '0;
      got      <= 1'b0;
      pull_low <= 1'b0;
    end else if (stop_ev) begin
      ph       <= PH_IDLE;
      got      <= 1'b0;
      pull_low <= 1'b0;
    end else if (ev_load) begin
      // first bit of a fresh read byte goes out on this low phase
      tx       <= rdata;
      pull_low <= ~rdata[7];
      ptr      <= step_ptr(ptr);
      cnt      <= '0;
      ph       <= PH_TX;
    end else begin
      unique case (ph)
        PH_RX: begin
          if (scl_rise) begin
            sh <= {sh[6:0], sda_lvl};
            if (cnt == 4'd7) begin
              cnt <= '0;
              got <= 1'b1;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end else if (byte_in) begin
            got <= 1'b0;
            if (is_addr) begin
              is_addr <= 1'b0;
              if (hit) begin
                rd       <= sh[0];
                first    <= ~sh[0];
                pull_low <= 1'b1;
                ph       <= PH_ACK;
              end else begin
                ph <= PH_IDLE;
              end
            end else begin
              if (first) begin
                first <= 1'b0;
                ptr   <= sh;
              end else begin
                ptr <= step_ptr(ptr);
              end
              pull_low <= 1'b1;
              ph       <= PH_ACK;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            pull_low <= 1'b0;
            cnt      <= '0;
            ph       <= PH_RX;
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              pull_low <= 1'b0;
              ph       <= PH_HACK;
            end else begin
              tx       <= {tx[6:0], 1'b0};
              pull_low <= ~tx[6];
            end
          end
        end
        PH_HACK: begin
          if (scl_rise) more <= ~sda_lvl;
          else if (scl_fall) ph <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pd_target.sv
module pd_target #(
  parameter logic [3:0] BASE_HI  = 4'hA,
  parameter logic [3:0] ALIAS_HI = 4'h6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [pd_pkg::STORE_BITS-1:0] IMAGE = pd_pkg::build_image()
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int AW = pd_pkg::STORE_AW;

  logic          scl_lvl;
  logic          sda_lvl;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_ev;
  logic          stop_ev;
  logic          st_we;
  logic [AW-1:0] ptr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          ev_addr_ack;
  logic          ev_addr_nack;
  logic [6:0]    ev_addr;
  logic          ev_load;

  pd_linesync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  pd_engine #(.AW(AW), .BASE_HI(BASE_HI), .ALIAS_HI(ALIAS_HI)) eng_i (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .slot(strap_i), .prot(wp_i), .rdata(rdata), .pull_low(sda_oe),
    .st_we(st_we), .ptr(ptr), .wdata(wdata), .ev_addr_ack(ev_addr_ack),
    .ev_addr_nack(ev_addr_nack), .ev_addr(ev_addr), .ev_load(ev_load)
  );

  pd_store #(.DEPTH(pd_pkg::STORE_DEPTH), .AW(AW), .IMAGE(IMAGE)) store_i (
    .clk(clk), .rst_n(rst_n), .we(st_we), .addr(ptr),
    .wdata(wdata), .rdata(rdata)
  );

  assign sda_o = 1'b0;
endmodule

// File: rtl/pd_target_chk.sv
module pd_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       wp_i,
  input logic [2:0] strap_i,
  input logic       sda_oe,
  input logic       stop_ev,
  input logic       ev_addr_ack,
  input logic       ev_addr_nack,
  input logic [6:0] ev_addr,
  input logic       ev_load,
  input logic [7:0] ptr
);
  // R1 / R2: an acknowledged address lies in an allowed window for this slot
  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_ack |-> (ev_addr[2:0] == strap_i) &&
                    ((ev_addr[6:3] == 4'b1010) || ((ev_addr[6:3] == 4'b0110) && !wp_i)));

  // R1: an acknowledged address is followed by the pull-low
  assert_addr_ack_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_ack |=> sda_oe);

  // R3: a rejected address leaves the line released
  assert_nack_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_nack |=> !sda_oe);

  // R7: every byte fetched for reading moves the pointer by one
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (ptr == 8'($past(ptr) + 8'd1)));

  // R9: the enable moves only in the clock-low phase
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R9: a stop leaves the line released
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R10: released while held in reset
  always @(posedge clk) begin
    if (!rst_n) assert_reset_release_R10: assert (!sda_oe);
  end
endmodule

bind pd_target pd_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wp_i(wp_i), .strap_i(strap_i),
  .sda_oe(sda_oe), .stop_ev(stop_ev), .ev_addr_ack(ev_addr_ack),
  .ev_addr_nack(ev_addr_nack), .ev_addr(ev_addr), .ev_load(ev_load), .ptr(ptr)
);

// File: tb/pd_target_tb.sv
module pd_target_tb_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'd2;
  logic       wp = 1'b0;
  logic       sda_o;
  logic       sda_oe;
  logic       sda_line;

  int tests = 0;
  int fails = 0;
  int scl_high_moves = 0;
  bit finished = 0;
  logic prev_oe = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  int    act_q[$];
  int    ref_mem[256];

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~(sda_oe & ~sda_o);

  pd_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        int a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, a, e);
      end
    end
  end

  // R9 watch: enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && m_scl) scl_high_moves++;
    prev_oe <= sda_oe;
  end

  task automatic expect_item(string tag, int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wait_q();
    m_scl = 1'b1; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    b = sda_line;
    m_scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    act_q.push_back(int'(a));
  endtask

  task automatic recv_byte(input logic host_nack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(host_nack);
    act_q.push_back(int'(v));
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = ((i * 37) % 256) ^ 'h5C;
    repeat (5) @(negedge clk);
    check("R10 enable released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 enable released after reset", int'(sda_oe), 0);

    // R10 / R11: current-address read from the reset pointer
    expect_item("R1 ack on read address", 0);
    expect_item("R10 image byte 0", ref_mem[0]);
    expect_item("R11 image byte 1", ref_mem[1]);
    bus_start(); send_byte(8'hA5); recv_byte(1'b0); recv_byte(1'b1);
    drain();
    check("R8 released after host NACK", int'(sda_oe), 0);
    bus_stop(); drain();
    check("R9 released after stop", int'(sda_oe), 0);

    // R1 / R4: pointer write then two data bytes
    expect_item("R1 ack primary write address", 0);
    expect_item("R4 ack pointer byte", 0);
    expect_item("R4 ack data byte AA", 0);
    expect_item("R4 ack data byte BB", 0);
    bus_start(); send_byte(8'hA4); send_byte(8'h10); send_byte(8'hAA); send_byte(8'hBB);
    bus_stop(); drain();
    ref_mem[16] = 'hAA; ref_mem[17] = 'hBB;

    // R6: random read with repeated start
    expect_item("R6 ack write address", 0);
    expect_item("R6 ack pointer", 0);
    expect_item("R6 ack read address", 0);
    expect_item("R6 byte at 0x10", ref_mem[16]);
    expect_item("R4 byte at 0x11", ref_mem[17]);
    bus_start(); send_byte(8'hA4); send_byte(8'h10);
    bus_start(); send_byte(8'hA5); recv_byte(1'b0); recv_byte(1'b1);
    bus_stop(); drain();

    // R3: other slot, then further bytes stay unacknowledged
    expect_item("R3 NACK other slot", 1);
    expect_item("R3 later byte NACK", 1);
    expect_item("R3 still released", 1);
    bus_start(); send_byte(8'hAA); send_byte(8'h00); send_byte(8'h00);
    bus_stop(); drain();

    // R2 / R5 with protection on
    wp = 1'b1;
    expect_item("R2 alias NACK while protected", 1);
    bus_start(); send_byte(8'h64); bus_stop(); drain();
    expect_item("R5 ack address", 0);
    expect_item("R5 ack pointer", 0);
    expect_item("R5 ack protected data", 0);
    bus_start(); send_byte(8'hA4); send_byte(8'h10); send_byte(8'h11);
    bus_stop(); drain();
    expect_item("R5 ack address", 0);
    expect_item("R5 ack pointer", 0);
    expect_item("R5 ack read address", 0);
    expect_item("R5 store unchanged", ref_mem[16]);
    bus_start(); send_byte(8'hA4); send_byte(8'h10);
    bus_start(); send_byte(8'hA5); recv_byte(1'b1);
    bus_stop(); drain();

    // R2 / R7: alias write across the top, then wrap read
    wp = 1'b0;
    expect_item("R2 alias ack unprotected", 0);
    expect_item("R7 ack pointer FE", 0);
    expect_item("R7 ack data 01", 0);
    expect_item("R7 ack data 02", 0);
    expect_item("R7 ack data 03", 0);
    bus_start(); send_byte(8'h64); send_byte(8'hFE);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    bus_stop(); drain();
    ref_mem[254] = 1; ref_mem[255] = 2; ref_mem[0] = 3;
    expect_item("R7 ack alias write", 0);
    expect_item("R7 ack pointer", 0);
    expect_item("R7 ack alias read", 0);
    expect_item("R7 byte FE", 1);
    expect_item("R7 byte FF", 2);
    expect_item("R7 wrapped byte 00", 3);
    bus_start(); send_byte(8'h64); send_byte(8'hFE);
    bus_start(); send_byte(8'h65); recv_byte(1'b0); recv_byte(1'b0); recv_byte(1'b1);
    bus_stop(); drain();

    // R11: pointer left at 0x01 by the wrap read
    expect_item("R11 ack current read", 0);
    expect_item("R11 continues at 0x01", ref_mem[1]);
    bus_start(); send_byte(8'hA5); recv_byte(1'b1);
    bus_stop(); drain();

    // R1 / R3 with a different strap
    strap = 3'd5;
    repeat (4) @(negedge clk);
    expect_item("R1 ack slot 5", 0);
    bus_start(); send_byte(8'hAA); bus_stop(); drain();
    expect_item("R3 NACK old slot", 1);
    bus_start(); send_byte(8'hA4); bus_stop(); drain();

    repeat (10) @(negedge clk);
    check("R9 no enable change while SCL high", scl_high_moves, 0);
    check("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule